// File: doc/BRIEF.md
# Counter Overflow Request Routing Registers

This block holds four enable words that decide which counter overflows raise which of four request lines: a normal interrupt, a fast interrupt, a reset request and a debug request. The sources are three event counters and one cycle counter. The block does not contain the counters. It sees each of them only as an overflow status bit on the `ovf_flags` input. The bit at index 3 is the cycle counter, and bits 2:0 are event counters 2, 1 and 0.

Software reaches the enable words through a small register-access port. A 3-bit index selects one of eight aliases. Each destination has two aliases: one where writing ones turns sources on, and one where writing ones turns them off. Reads through either alias return the current word. Every access carries a privilege flag. A user-mode access is honoured only when the permit input is high. A refused access leaves all state alone and raises an error pulse.

Each request output is registered. It is asserted when any enabled source of that destination shows overflow.

Top module: `ovf_route_regs`

## Requirements
- R1: In the 32-bit register word, bit 31 stands for the cycle counter and bits 2, 1, 0 for event counters 2, 1, 0. Bits 30:3 always read as zero, and data written to them has no effect.
- R2: Index values 0, 1, 2, 3 select the set alias of the normal interrupt, fast interrupt, reset and debug destinations. Index values 4, 5, 6, 7 select the clear alias of the same four destinations, in the same order.
- R3: A granted write to a set alias turns on every source whose bit is 1. Sources whose bit is 0 keep their state.
- R4: A granted write to a clear alias turns off every source whose bit is 1. Sources whose bit is 0 keep their state.
- R5: A granted read of either alias of a destination presents that destination's enable word on `acc_rdata` in the cycle after the access.
- R6: `irq_n`, `fiq_n` and `rst_req_n` are active low. Each goes low one cycle after any of its enabled sources shows overflow.
- R7: `dbg_req` is active high. It goes high one cycle after any debug-enabled source shows overflow.
- R8: A request output returns to its inactive level one cycle after its enabled overflows go away, whether because the status cleared or because the enable was cleared.
- R9: A privileged access is always granted. A user access is granted only while `user_permit` is high.
- R10: A refused access changes no enable word. It returns zero on `acc_rdata` in the next cycle and raises `acc_err` for that one cycle.
- R11: After reset, all enable words are zero, the three active-low outputs are high, `dbg_req` is low, and `acc_rdata` and `acc_err` are zero.
- R12: An access to one destination's aliases never changes the enable words of the other destinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 3 | Alias index |
| acc_wdata | input | 32 | Write data |
| acc_priv | input | 1 | Access is privileged |
| user_permit | input | 1 | Allows user-mode accesses |
| ovf_flags | input | 4 | Overflow status; bit 3 = cycle counter, bits 2:0 = event counters |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_err | output | 1 | One-cycle pulse after a refused access |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |
| rst_req_n | output | 1 | Reset request, active low |
| dbg_req | output | 1 | Debug request, active high |

## Verification
Directed steps are tried first.
- Writing all ones through a set alias shows that the reserved bits are dropped and that bit 31 maps onto the cycle counter.
- Single-bit clears, and writes of zero, show that unselected bits are left alone.
- Overflow on a single source, with the source enabled for only one destination, shows that each output follows only its own word and carries its own polarity.
- User accesses with the permit low and then high show that grant and refusal are told apart.

After these steps, a long random mix of accesses and overflow patterns is run. The mix covers both privilege levels, both permit values and all eight aliases. It exposes ordering faults between set, clear and read, which the directed steps cannot.

// File: rtl/ovf_route_pkg.sv
package ovf_route_pkg;

   // destinations, in alias order
   typedef enum logic [1:0] {
      DST_IRQ = 2'd0,
      DST_FIQ = 2'd1,
      DST_RST = 2'd2,
      DST_DBG = 2'd3
   } dest_e;

   localparam int NUM_DEST = 4;

   // polarity of each destination's output line
   function automatic logic dest_active_low(input int d);
      return (d != int'(DST_DBG));
   endfunction

endpackage

// File: rtl/ovf_access_gate.sv
module ovf_access_gate #(
   parameter int NUM_DEST = 4,
   localparam int SEL_W = $clog2(NUM_DEST),
   localparam int IDX_W = SEL_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [IDX_W-1:0]    acc_index,
   input  logic                acc_priv,
   input  logic                user_permit,
   output logic [NUM_DEST-1:0] set_stb,
   output logic [NUM_DEST-1:0] clr_stb,
   output logic                rd_stb,
   output logic                deny,
   output logic [SEL_W-1:0]    dest_sel,
   output logic                err_q
);

   initial begin
      if (NUM_DEST < 2) $fatal(1, "NUM_DEST must be at least 2");
   end

   logic grant;
   logic is_clear;

   assign grant    = acc_valid & (acc_priv | user_permit);
   assign deny     = acc_valid & ~acc_priv & ~user_permit;
   assign is_clear = acc_index[IDX_W-1];
   assign dest_sel = acc_index[SEL_W-1:0];
   assign rd_stb   = grant & ~acc_write;

   for (genvar d = 0; d < NUM_DEST; d++) begin : g_dec
      assign set_stb[d] = grant & acc_write & ~is_clear & (dest_sel == SEL_W'(d));
      assign clr_stb[d] = grant & acc_write &  is_clear & (dest_sel == SEL_W'(d));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= deny;
   end

   // R10
   deny_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_priv && !user_permit) |=> err_q);

   // R9
   priv_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_priv) |=> !err_q);

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({set_stb, clr_stb}) <= 1);

endmodule

// File: rtl/ovf_enable_bank.sv
module ovf_enable_bank #(
   parameter int NUM_EVT = 3,
   parameter int DATA_W  = 32,
   parameter int CYC_BIT = 31,
   localparam int NSRC   = NUM_EVT + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_stb,
   input  logic              clr_stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [NSRC-1:0]   en_q
);

   initial begin
      if (CYC_BIT >= DATA_W) $fatal(1, "CYC_BIT outside word");
      if (NUM_EVT >= CYC_BIT) $fatal(1, "event bits overlap cycle bit");
   end

   // gather source bits from the bus word; reserved bits are not looked at
   logic [NSRC-1:0] wsrc;
   assign wsrc = {wdata[CYC_BIT], wdata[NUM_EVT-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= '0;
      else if (set_stb) en_q <= en_q | wsrc;
      else if (clr_stb) en_q <= en_q & ~wsrc;
   end

   // R3
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((en_q & $past(wsrc)) == $past(wsrc)));

   // R4
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((en_q & $past(wsrc)) == '0));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(en_q));

endmodule

// File: rtl/ovf_request_drive.sv
module ovf_request_drive #(
   parameter int NSRC       = 4,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] en,
   input  logic [NSRC-1:0] ovf,
   output logic            req_o
);

   logic hit;
   assign hit = |(en & ovf);

   if (ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o <= 1'b1;
         else        req_o <= ~hit;
      end
      // R8
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ovf == '0) |=> req_o);
      // R6
      raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((en[0] && ovf[0]) || (en[NSRC-1] && ovf[NSRC-1])) |=> !req_o);
   end else begin : g_high
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_o <= 1'b0;
         else        req_o <= hit;
      end
      // R8
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en == '0) |=> !req_o);
      // R7
      raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((en[0] && ovf[0]) || (en[NSRC-1] && ovf[NSRC-1])) |=> req_o);
   end

endmodule

// File: rtl/ovf_route_regs.sv
module ovf_route_regs
   import ovf_route_pkg::*;
#(
   parameter int NUM_EVT = 3,
   parameter int DATA_W  = 32,
   parameter int CYC_BIT = 31,
   localparam int NSRC   = NUM_EVT + 1,
   localparam int SEL_W  = $clog2(NUM_DEST),
   localparam int IDX_W  = SEL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [IDX_W-1:0]  acc_index,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              acc_priv,
   input  logic              user_permit,
   input  logic [NSRC-1:0]   ovf_flags,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_err,
   output logic              irq_n,
   output logic              fiq_n,
   output logic              rst_req_n,
   output logic              dbg_req
);

   logic [NUM_DEST-1:0] set_stb, clr_stb;
   logic                rd_stb, deny;
   logic [SEL_W-1:0]    dest_sel;
   logic [NSRC-1:0]     en_w [NUM_DEST];
   logic [NUM_DEST-1:0] req_w;
   logic [DATA_W-1:0]   rd_word;
   logic [DATA_W-1:0]   rdata_q;

   ovf_access_gate #(.NUM_DEST(NUM_DEST)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_index(acc_index),
      .acc_priv(acc_priv), .user_permit(user_permit),
      .set_stb(set_stb), .clr_stb(clr_stb), .rd_stb(rd_stb), .deny(deny),
      .dest_sel(dest_sel), .err_q(acc_err)
   );

   for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
      ovf_enable_bank #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .CYC_BIT(CYC_BIT)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .set_stb(set_stb[d]), .clr_stb(clr_stb[d]),
         .wdata(acc_wdata), .en_q(en_w[d])
      );
      ovf_request_drive #(.NSRC(NSRC), .ACTIVE_LOW(dest_active_low(d))) u_drv (
         .clk(clk), .rst_n(rst_n),
         .en(en_w[d]), .ovf(ovf_flags), .req_o(req_w[d])
      );
   end

   // place the selected word's source bits back at their bus positions
   always_comb begin
      rd_word                = '0;
      rd_word[NUM_EVT-1:0]   = en_w[dest_sel][NUM_EVT-1:0];
      rd_word[CYC_BIT]       = en_w[dest_sel][NUM_EVT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata_q <= '0;
      else if (rd_stb)    rdata_q <= rd_word;
      else if (acc_valid) rdata_q <= '0;
   end

   assign acc_rdata = rdata_q;
   assign irq_n     = req_w[DST_IRQ];
   assign fiq_n     = req_w[DST_FIQ];
   assign rst_req_n = req_w[DST_RST];
   assign dbg_req   = req_w[DST_DBG];

   // R10
   deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deny |=> (acc_rdata == '0));

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> (acc_rdata[CYC_BIT-1:NUM_EVT] == '0));

endmodule

// File: tb/tb_ovf_route_regs.sv
module tb_ovf_route_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0, acc_priv = 0, user_permit = 0;
   logic [2:0]  acc_index = '0;
   logic [31:0] acc_wdata = '0;
   logic [3:0]  ovf_flags = '0;
   logic [31:0] acc_rdata;
   logic        acc_err, irq_n, fiq_n, rst_req_n, dbg_req;

   int compared = 0;
   int mismatched = 0;
   logic [3:0] m_en [4];

   always #5 clk = ~clk;

   ovf_route_regs dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_index(acc_index), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
      .user_permit(user_permit), .ovf_flags(ovf_flags), .acc_rdata(acc_rdata),
      .acc_err(acc_err), .irq_n(irq_n), .fiq_n(fiq_n), .rst_req_n(rst_req_n),
      .dbg_req(dbg_req)
   );

   function automatic logic [31:0] pack_word(input logic [3:0] e);
      return {e[3], 28'd0, e[2:0]};
   endfunction

   function automatic logic [3:0] src_of(input logic [31:0] w);
      return {w[31], w[2:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one clocked step; compares all outputs against the bench model
   task automatic step(input logic v, input logic w, input logic [2:0] idx,
                       input logic [31:0] wd, input logic pr, input logic pm,
                       input logic [3:0] ov);
      logic [3:0]  old_en [4];
      logic        granted, refused;
      logic [31:0] exp_rd;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_index = idx; acc_wdata = wd;
      acc_priv = pr; user_permit = pm; ovf_flags = ov;
      @(posedge clk);
      #1;
      for (int d = 0; d < 4; d++) old_en[d] = m_en[d];
      granted = v & (pr | pm);
      refused = v & ~pr & ~pm;
      exp_rd  = acc_rdata;
      if (granted && !w)  exp_rd = pack_word(old_en[idx[1:0]]);
      else if (v)         exp_rd = '0;
      if (granted && w) begin
         if (!idx[2]) m_en[idx[1:0]] = old_en[idx[1:0]] | src_of(wd);
         else         m_en[idx[1:0]] = old_en[idx[1:0]] & ~src_of(wd);
      end
      if (v) check("R5 rdata", acc_rdata, exp_rd);
      check("R10 err", {31'd0, acc_err}, {31'd0, refused});
      check("R6 irq_n", {31'd0, irq_n}, {31'd0, ~|(old_en[0] & ov)});
      check("R6 fiq_n", {31'd0, fiq_n}, {31'd0, ~|(old_en[1] & ov)});
      check("R6 rst_req_n", {31'd0, rst_req_n}, {31'd0, ~|(old_en[2] & ov)});
      check("R7 dbg_req", {31'd0, dbg_req}, {31'd0, |(old_en[3] & ov)});
   endtask

   task automatic rd(input logic [2:0] idx, input logic [31:0] exp, input string req);
      step(1, 0, idx, '0, 1, 0, 4'h0);
      check(req, acc_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed;
      void'($urandom(seed));
      for (int d = 0; d < 4; d++) m_en[d] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      check("R11 irq_n", {31'd0, irq_n}, 32'd1);
      check("R11 fiq_n", {31'd0, fiq_n}, 32'd1);
      check("R11 rst_req_n", {31'd0, rst_req_n}, 32'd1);
      check("R11 dbg_req", {31'd0, dbg_req}, 32'd0);
      check("R11 rdata", acc_rdata, 32'd0);
      check("R11 err", {31'd0, acc_err}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all ones written, only mapped bits stick
      step(1, 1, 3'd0, 32'hFFFF_FFFF, 1, 0, 4'h0);
      rd(3'd0, 32'h8000_0007, "R1 mapped bits");
      // R5: clear alias reads the same word
      rd(3'd4, 32'h8000_0007, "R5 clear alias read");
      // R12: other destinations untouched
      rd(3'd1, 32'h0, "R12 fiq word");
      rd(3'd3, 32'h0, "R12 dbg word");
      // R4: clear one bit
      step(1, 1, 3'd4, 32'h0000_0002, 1, 0, 4'h0);
      rd(3'd0, 32'h8000_0005, "R4 clear bit1");
      // R3: write zeros to set alias changes nothing
      step(1, 1, 3'd0, 32'h0, 1, 0, 4'h0);
      rd(3'd0, 32'h8000_0005, "R3 zero write");
      // R6 / R8: overflow on event 0
      step(0, 0, 3'd0, '0, 0, 0, 4'b0001);
      check("R6 irq low", {31'd0, irq_n}, 32'd0);
      check("R6 fiq idle", {31'd0, fiq_n}, 32'd1);
      step(0, 0, 3'd0, '0, 0, 0, 4'b0000);
      check("R8 irq released", {31'd0, irq_n}, 32'd1);
      // R2 / R7: debug set alias index 3, cycle counter bit
      step(1, 1, 3'd3, 32'h8000_0000, 1, 0, 4'h0);
      step(0, 0, 3'd0, '0, 0, 0, 4'b1000);
      check("R7 dbg high", {31'd0, dbg_req}, 32'd1);
      // R8: clearing the enable releases the line while overflow stays
      step(1, 1, 3'd7, 32'h8000_0000, 1, 0, 4'b1000);
      step(0, 0, 3'd0, '0, 0, 0, 4'b1000);
      check("R8 dbg released", {31'd0, dbg_req}, 32'd0);
      // R2: reset destination via index 2
      step(1, 1, 3'd2, 32'h0000_0002, 1, 0, 4'h0);
      step(0, 0, 3'd0, '0, 0, 0, 4'b0010);
      check("R2 rst_req_n low", {31'd0, rst_req_n}, 32'd0);
      // R10: refused user write
      step(1, 1, 3'd1, 32'hFFFF_FFFF, 0, 0, 4'h0);
      check("R10 err pulse", {31'd0, acc_err}, 32'd1);
      check("R10 rdata zero", acc_rdata, 32'd0);
      step(0, 0, 3'd0, '0, 0, 0, 4'h0);
      check("R10 err one cycle", {31'd0, acc_err}, 32'd0);
      rd(3'd1, 32'h0, "R10 no change");
      // R9: permitted user write
      step(1, 1, 3'd1, 32'h0000_0004, 0, 1, 4'h0);
      check("R9 no err", {31'd0, acc_err}, 32'd0);
      rd(3'd5, 32'h0000_0004, "R9 user write took");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0], r[1], r[4:2], $urandom, r[5] | r[6], r[7],
              r[8] ? r[12:9] : 4'h0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule